// File: doc/BRIEF.md
# Assignable Transmit/Receive Byte FIFO Pair

This block holds two byte queues for a two-wire serial bus controller. One queue carries
bytes out toward the bus and one carries bytes in from it. The host side writes the outgoing
queue and reads the incoming one. The bus side of each queue can be handed to either the
master engine or the slave engine. Each queue has its own ownership select, so all four
pairings are legal: both queues to the master, both to the slave, or one queue to each engine.

An engine that does not own a queue sees it as permanently unavailable. Its strobes toward
that queue do nothing. Each queue has a programmable trigger level. The resulting request
line can feed an interrupt controller or a DMA channel. Occupancy counts, an outgoing-empty
flag, an incoming-full flag and sticky error bits for dropped accesses are also provided.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both levels are 0, `tx_empty`=1, `rx_full`=0, `tx_req`=1 (since `tx_trig` resets to 0 and level 0 <= 0), and all four sticky error bits are 0.
- R2: Each queue holds up to DEPTH (default 8) bytes and returns them in write order. The head byte is visible on the read data port before the pop strobe (first-word fall-through).
- R3: A push to a full queue is dropped, leaving contents and level unchanged, and sets that queue's sticky overflow bit (`tx_ovf` or `rx_ovf`).
- R4: A pop from an empty queue is dropped and sets that queue's sticky underflow bit (`tx_unf` or `rx_unf`).
- R5: Ownership select value 0 gives a queue's bus side to the master engine (`m_*` ports). Value 1 gives it to the slave engine (`s_*` ports).
- R6: The non-owning engine sees the outgoing queue as empty (`*_tx_empty`=1, `*_tx_data`=0) and the incoming queue as full (`*_rx_full`=1). Its strobes change neither level nor error bits.
- R7: `tx_req` is 1 exactly when the outgoing level is less than or equal to `tx_trig` (0..7).
- R8: `rx_req` is 1 exactly when the incoming level is greater than or equal to `rx_trig` (0..7).
- R9: When a queue's ownership select changes, that queue is emptied at the next clock edge. Every strobe to that queue in that cycle is discarded without setting error bits.
- R10: A push and a pop in the same cycle are each judged against the level before the edge. On a partly filled queue the level holds and order is kept. When full, the pop wins and the push overflows. When empty, the push wins and the pop underflows.
- R11: `tx_empty` is 1 exactly when the outgoing level is 0, and `rx_full` is 1 exactly when the incoming level equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_sel | input | 1 | Outgoing queue owner: 0 master, 1 slave |
| rx_sel | input | 1 | Incoming queue owner: 0 master, 1 slave |
| tx_trig | input | 3 | Outgoing request threshold |
| rx_trig | input | 3 | Incoming request threshold |
| host_tx_wr | input | 1 | Host write strobe into outgoing queue |
| host_tx_data | input | 8 | Host write byte |
| host_rx_rd | input | 1 | Host pop strobe from incoming queue |
| host_rx_data | output | 8 | Incoming queue head byte |
| m_tx_pop | input | 1 | Master pop from outgoing queue |
| m_tx_data | output | 8 | Outgoing head byte as seen by master |
| m_tx_empty | output | 1 | Outgoing queue empty as seen by master |
| s_tx_pop | input | 1 | Slave pop from outgoing queue |
| s_tx_data | output | 8 | Outgoing head byte as seen by slave |
| s_tx_empty | output | 1 | Outgoing queue empty as seen by slave |
| m_rx_push | input | 1 | Master push into incoming queue |
| m_rx_data | input | 8 | Master push byte |
| m_rx_full | output | 1 | Incoming queue full as seen by master |
| s_rx_push | input | 1 | Slave push into incoming queue |
| s_rx_data | input | 8 | Slave push byte |
| s_rx_full | output | 1 | Incoming queue full as seen by slave |
| tx_level | output | 4 | Outgoing occupancy |
| rx_level | output | 4 | Incoming occupancy |
| tx_empty | output | 1 | Outgoing queue empty |
| rx_full | output | 1 | Incoming queue full |
| tx_req | output | 1 | Outgoing threshold request |
| rx_req | output | 1 | Incoming threshold request |
| tx_ovf | output | 1 | Sticky outgoing overflow |
| tx_unf | output | 1 | Sticky outgoing underflow |
| rx_ovf | output | 1 | Sticky incoming overflow |
| rx_unf | output | 1 | Sticky incoming underflow |

## Verification
The properties that compare an ownership select with its value one cycle earlier assume the select is held at 0 while reset is asserted. The internal copy of the select also resets to 0, so the first cycle out of reset never counts as an ownership change. The stimulus keeps both selects at 0 through every reset and changes them only between clock edges. It also drives every strobe and data input on the falling edge, so each access lands in exactly one rising-edge cycle.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
   typedef enum logic {
      ENG_MASTER = 1'b0,
      ENG_SLAVE  = 1'b1
   } engine_e;
endpackage

// File: rtl/fifo_ring.sv
module fifo_ring #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic              pop,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  level,
   output logic              ovf,
   output logic              unf
);
   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              push_ok, pop_ok, is_full, is_empty;

   assign is_full  = (level == CNT_W'(DEPTH));
   assign is_empty = (level == '0);
   assign push_ok  = push && !is_full && !flush;
   assign pop_ok   = pop && !is_empty && !flush;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + CNT_W'(1);
            2'b01:   level <= level - CNT_W'(1);
            default: level <= level;
         endcase
         if (push && is_full)  ovf <= 1'b1;
         if (pop && is_empty)  unf <= 1'b1;
      end
   end
endmodule

// File: rtl/engine_select.sv
module engine_select
   import fifo_pair_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  engine_e           owner,
   input  logic              m_stb,
   input  logic              s_stb,
   input  logic [DATA_W-1:0] m_wdata,
   input  logic [DATA_W-1:0] s_wdata,
   input  logic              busy,
   input  logic [DATA_W-1:0] rdata,
   output logic              stb,
   output logic [DATA_W-1:0] wdata,
   output logic              m_busy,
   output logic              s_busy,
   output logic [DATA_W-1:0] m_rdata,
   output logic [DATA_W-1:0] s_rdata
);
   logic own_m;
   assign own_m   = (owner == ENG_MASTER);
   assign stb     = own_m ? m_stb : s_stb;
   assign wdata   = own_m ? m_wdata : s_wdata;
   assign m_busy  = own_m ? busy : 1'b1;
   assign s_busy  = own_m ? 1'b1 : busy;
   assign m_rdata = own_m ? rdata : '0;
   assign s_rdata = own_m ? '0 : rdata;
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
   import fifo_pair_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int TRIG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_sel,
   input  logic              rx_sel,
   input  logic [TRIG_W-1:0] tx_trig,
   input  logic [TRIG_W-1:0] rx_trig,
   input  logic              host_tx_wr,
   input  logic [DATA_W-1:0] host_tx_data,
   input  logic              host_rx_rd,
   output logic [DATA_W-1:0] host_rx_data,
   input  logic              m_tx_pop,
   output logic [DATA_W-1:0] m_tx_data,
   output logic              m_tx_empty,
   input  logic              s_tx_pop,
   output logic [DATA_W-1:0] s_tx_data,
   output logic              s_tx_empty,
   input  logic              m_rx_push,
   input  logic [DATA_W-1:0] m_rx_data,
   output logic              m_rx_full,
   input  logic              s_rx_push,
   input  logic [DATA_W-1:0] s_rx_data,
   output logic              s_rx_full,
   output logic [CNT_W-1:0]  tx_level,
   output logic [CNT_W-1:0]  rx_level,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              tx_req,
   output logic              rx_req,
   output logic              tx_ovf,
   output logic              tx_unf,
   output logic              rx_ovf,
   output logic              rx_unf
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("i2c_fifo_pair: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("i2c_fifo_pair: DATA_W must be positive");
      end
   endgenerate

   engine_e tx_own, rx_own, tx_own_q, rx_own_q;
   logic    tx_flush, rx_flush;
   logic    tx_pop_stb, rx_push_stb;
   logic [DATA_W-1:0] tx_head, rx_wdata, tx_unused_w;

   assign tx_own = engine_e'(tx_sel);
   assign rx_own = engine_e'(rx_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_own_q <= ENG_MASTER;
         rx_own_q <= ENG_MASTER;
      end else begin
         tx_own_q <= tx_own;
         rx_own_q <= rx_own;
      end
   end

   assign tx_flush = (tx_own != tx_own_q);
   assign rx_flush = (rx_own != rx_own_q);

   // Outgoing queue: host pushes, owning engine pops.
   engine_select #(.DATA_W(DATA_W)) u_tx_sel (
      .owner   (tx_own),
      .m_stb   (m_tx_pop),
      .s_stb   (s_tx_pop),
      .m_wdata ('0),
      .s_wdata ('0),
      .busy    (tx_empty),
      .rdata   (tx_head),
      .stb     (tx_pop_stb),
      .wdata   (tx_unused_w),
      .m_busy  (m_tx_empty),
      .s_busy  (s_tx_empty),
      .m_rdata (m_tx_data),
      .s_rdata (s_tx_data)
   );

   fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush),
      .push  (host_tx_wr),
      .pop   (tx_pop_stb),
      .wdata (host_tx_data),
      .rdata (tx_head),
      .level (tx_level),
      .ovf   (tx_ovf),
      .unf   (tx_unf)
   );

   // Incoming queue: owning engine pushes, host pops.
   logic              rx_unused_m, rx_unused_s;
   logic [DATA_W-1:0] rx_unused_md, rx_unused_sd;

   engine_select #(.DATA_W(DATA_W)) u_rx_sel (
      .owner   (rx_own),
      .m_stb   (m_rx_push),
      .s_stb   (s_rx_push),
      .m_wdata (m_rx_data),
      .s_wdata (s_rx_data),
      .busy    (rx_full),
      .rdata   ('0),
      .stb     (rx_push_stb),
      .wdata   (rx_wdata),
      .m_busy  (m_rx_full),
      .s_busy  (s_rx_full),
      .m_rdata (rx_unused_md),
      .s_rdata (rx_unused_sd)
   );
   assign rx_unused_m = ^rx_unused_md;
   assign rx_unused_s = ^rx_unused_sd;

   fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush),
      .push  (rx_push_stb),
      .pop   (host_rx_rd),
      .wdata (rx_wdata),
      .rdata (host_rx_data),
      .level (rx_level),
      .ovf   (rx_ovf),
      .unf   (rx_unf)
   );

   assign tx_empty = (tx_level == '0);
   assign rx_full  = (rx_level == CNT_W'(DEPTH));
   assign tx_req   = (tx_level <= CNT_W'(tx_trig));
   assign rx_req   = (rx_level >= CNT_W'(rx_trig));

   logic unused_ok;
   assign unused_ok = rx_unused_m ^ rx_unused_s ^ (^tx_unused_w);
endmodule

// File: rtl/i2c_fifo_pair_chk.sv
module i2c_fifo_pair_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_sel,
   input logic              rx_sel,
   input logic              host_tx_wr,
   input logic              m_tx_pop,
   input logic              s_tx_pop,
   input logic [DATA_W-1:0] m_tx_data,
   input logic [DATA_W-1:0] s_tx_data,
   input logic              m_tx_empty,
   input logic              s_tx_empty,
   input logic              m_rx_full,
   input logic              s_rx_full,
   input logic [CNT_W-1:0]  tx_level,
   input logic [CNT_W-1:0]  rx_level,
   input logic              tx_ovf,
   input logic              rx_ovf
);
   logic tx_owner_pop;
   assign tx_owner_pop = tx_sel ? s_tx_pop : m_tx_pop;

   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= CNT_W'(DEPTH)) && (rx_level <= CNT_W'(DEPTH)));

   p_tx_hidden_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sel |-> (m_tx_empty && (m_tx_data == '0)));

   p_tx_hidden_s_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_sel |-> (s_tx_empty && (s_tx_data == '0)));

   p_rx_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sel |-> m_rx_full) and (!rx_sel |-> s_rx_full));

   p_tx_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sel != $past(tx_sel)) |=> (tx_level == '0));

   p_rx_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_sel != $past(rx_sel)) |=> (rx_level == '0));

   p_tx_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_wr && (tx_level == CNT_W'(DEPTH)) && (tx_sel == $past(tx_sel))) |=> tx_ovf);

   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tx_ovf) |-> tx_ovf) and ($past(rx_ovf) |-> rx_ovf));

   p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_wr && tx_owner_pop && (tx_level != '0) && (tx_level != CNT_W'(DEPTH))
       && (tx_sel == $past(tx_sel))) |=> $stable(tx_level));
endmodule

bind i2c_fifo_pair i2c_fifo_pair_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_sel     (tx_sel),
   .rx_sel     (rx_sel),
   .host_tx_wr (host_tx_wr),
   .m_tx_pop   (m_tx_pop),
   .s_tx_pop   (s_tx_pop),
   .m_tx_data  (m_tx_data),
   .s_tx_data  (s_tx_data),
   .m_tx_empty (m_tx_empty),
   .s_tx_empty (s_tx_empty),
   .m_rx_full  (m_rx_full),
   .s_rx_full  (s_rx_full),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .tx_ovf     (tx_ovf),
   .rx_ovf     (rx_ovf)
);

// File: tb/i2c_fifo_pair_test.sv
module i2c_fifo_pair_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_sel = 1'b0, rx_sel = 1'b0;
   logic [2:0] tx_trig = '0, rx_trig = '0;
   logic       host_tx_wr = 1'b0, host_rx_rd = 1'b0;
   logic [7:0] host_tx_data = '0, host_rx_data;
   logic       m_tx_pop = 1'b0, s_tx_pop = 1'b0;
   logic [7:0] m_tx_data, s_tx_data;
   logic       m_tx_empty, s_tx_empty;
   logic       m_rx_push = 1'b0, s_rx_push = 1'b0;
   logic [7:0] m_rx_data = '0, s_rx_data = '0;
   logic       m_rx_full, s_rx_full;
   logic [3:0] tx_level, rx_level;
   logic       tx_empty, rx_full, tx_req, rx_req;
   logic       tx_ovf, tx_unf, rx_ovf, rx_unf;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   i2c_fifo_pair uut (
      .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .rx_sel(rx_sel),
      .tx_trig(tx_trig), .rx_trig(rx_trig),
      .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
      .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
      .m_tx_pop(m_tx_pop), .m_tx_data(m_tx_data), .m_tx_empty(m_tx_empty),
      .s_tx_pop(s_tx_pop), .s_tx_data(s_tx_data), .s_tx_empty(s_tx_empty),
      .m_rx_push(m_rx_push), .m_rx_data(m_rx_data), .m_rx_full(m_rx_full),
      .s_rx_push(s_rx_push), .s_rx_data(s_rx_data), .s_rx_full(s_rx_full),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_empty(tx_empty), .rx_full(rx_full), .tx_req(tx_req), .rx_req(rx_req),
      .tx_ovf(tx_ovf), .tx_unf(tx_unf), .rx_ovf(rx_ovf), .rx_unf(rx_unf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic ceq(input string tag, input int act, input int exp);
      chk(act == exp, tag, act, exp);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      host_tx_wr = 1'b0; host_rx_rd = 1'b0;
      m_tx_pop = 1'b0; s_tx_pop = 1'b0;
      m_rx_push = 1'b0; s_rx_push = 1'b0;
   endtask

   task automatic do_reset();
      clear_strobes();
      tx_sel = 1'b0; rx_sel = 1'b0; tx_trig = '0; rx_trig = '0;
      rst_n = 1'b0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic host_write(input logic [7:0] d);
      host_tx_wr = 1'b1; host_tx_data = d;
      tick();
      host_tx_wr = 1'b0;
   endtask

   task automatic m_push_rx(input logic [7:0] d);
      m_rx_push = 1'b1; m_rx_data = d;
      tick();
      m_rx_push = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      ceq("R1 tx_level", tx_level, 0);
      ceq("R1 rx_level", rx_level, 0);
      ceq("R11 tx_empty after reset", tx_empty, 1);
      ceq("R11 rx_full after reset", rx_full, 0);
      ceq("R1 tx_req", tx_req, 1);
      ceq("R1 error bits", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
   endtask

   task automatic t_order();
      do_reset();
      for (int i = 0; i < 8; i++) host_write(8'hA0 + 8'(i));
      ceq("R2 tx_level full", tx_level, 8);
      ceq("R11 tx_empty when full", tx_empty, 0);
      ceq("R5 master sees data", m_tx_empty, 0);
      for (int i = 0; i < 8; i++) begin
         ceq("R2 order head", m_tx_data, 8'hA0 + i);
         m_tx_pop = 1'b1; tick(); m_tx_pop = 1'b0;
      end
      ceq("R2 drained", tx_level, 0);
      ceq("R11 tx_empty drained", tx_empty, 1);
   endtask

   task automatic t_overflow();
      do_reset();
      for (int i = 0; i < 8; i++) host_write(8'h10 + 8'(i));
      host_write(8'hEE);
      ceq("R3 tx level held", tx_level, 8);
      ceq("R3 tx_ovf set", tx_ovf, 1);
      ceq("R3 head unchanged", m_tx_data, 8'h10);
      for (int i = 0; i < 8; i++) m_push_rx(8'h30 + 8'(i));
      ceq("R11 rx_full", rx_full, 1);
      ceq("R5 m_rx_full owner", m_rx_full, 1);
      ceq("R3 rx_ovf clear before", rx_ovf, 0);
      m_push_rx(8'hEE);
      ceq("R3 rx_ovf set", rx_ovf, 1);
      ceq("R3 rx level held", rx_level, 8);
      ceq("R2 rx head", host_rx_data, 8'h30);
   endtask

   task automatic t_underflow();
      do_reset();
      m_tx_pop = 1'b1; tick(); m_tx_pop = 1'b0;
      ceq("R4 tx_unf set", tx_unf, 1);
      ceq("R4 tx level", tx_level, 0);
      host_rx_rd = 1'b1; tick(); host_rx_rd = 1'b0;
      ceq("R4 rx_unf set", rx_unf, 1);
      ceq("R4 rx level", rx_level, 0);
   endtask

   task automatic t_nonowner();
      do_reset();
      tx_sel = 1'b1; tick();
      host_write(8'h5A); host_write(8'h5B);
      ceq("R6 master tx hidden", m_tx_empty, 1);
      ceq("R6 master tx data zero", m_tx_data, 0);
      ceq("R5 slave tx visible", s_tx_empty, 0);
      ceq("R5 slave tx head", s_tx_data, 8'h5A);
      m_tx_pop = 1'b1; tick(); m_tx_pop = 1'b0;
      ceq("R6 master pop ignored", tx_level, 2);
      ceq("R6 no underflow", tx_unf, 0);
      s_tx_pop = 1'b1; tick(); s_tx_pop = 1'b0;
      ceq("R5 slave pop", s_tx_data, 8'h5B);
      rx_sel = 1'b1; tick();
      ceq("R6 master rx hidden", m_rx_full, 1);
      m_push_rx(8'h77);
      ceq("R6 master push ignored", rx_level, 0);
      ceq("R6 no overflow", rx_ovf, 0);
      s_rx_push = 1'b1; s_rx_data = 8'h55; tick(); s_rx_push = 1'b0;
      ceq("R5 slave push level", rx_level, 1);
      ceq("R5 slave push data", host_rx_data, 8'h55);
      ceq("R5 slave rx not full", s_rx_full, 0);
   endtask

   task automatic t_triggers();
      do_reset();
      tx_trig = 3'd2; rx_trig = 3'd3;
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         ceq("R7 tx_req vs level", tx_req, (i <= 2) ? 1 : 0);
         ceq("R8 rx_req vs level", rx_req, (i >= 3) ? 1 : 0);
         host_write(8'(i));
         m_push_rx(8'(i));
      end
      rx_trig = 3'd0; tx_trig = 3'd7;
      #1;
      ceq("R8 rx_req trig 0", rx_req, 1);
      ceq("R7 tx_req trig 7", tx_req, 1);
   endtask

   task automatic t_flush();
      do_reset();
      host_write(8'h01); host_write(8'h02); host_write(8'h03);
      for (int i = 0; i < 3; i++) m_push_rx(8'h40 + 8'(i));
      tx_sel = 1'b1; host_tx_wr = 1'b1; host_tx_data = 8'hFF;
      rx_sel = 1'b1; s_rx_push = 1'b1; s_rx_data = 8'hCC;
      tick();
      clear_strobes();
      ceq("R9 tx flushed", tx_level, 0);
      ceq("R9 rx flushed", rx_level, 0);
      ceq("R9 no error bits", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
      host_write(8'h09);
      ceq("R9 usable after flush", tx_level, 1);
      ceq("R9 new owner head", s_tx_data, 8'h09);
   endtask

   task automatic t_simul();
      do_reset();
      host_write(8'hB0); host_write(8'hB1); host_write(8'hB2);
      host_tx_wr = 1'b1; host_tx_data = 8'hB3; m_tx_pop = 1'b1;
      tick();
      clear_strobes();
      ceq("R10 level held", tx_level, 3);
      for (int i = 1; i < 4; i++) begin
         ceq("R10 order kept", m_tx_data, 8'hB0 + i);
         m_tx_pop = 1'b1; tick(); m_tx_pop = 1'b0;
      end
      host_tx_wr = 1'b1; host_tx_data = 8'hC0; m_tx_pop = 1'b1;
      tick();
      clear_strobes();
      ceq("R10 empty both: push wins", tx_level, 1);
      ceq("R10 empty both: underflow", tx_unf, 1);
      for (int i = 1; i < 8; i++) host_write(8'hC0 + 8'(i));
      host_tx_wr = 1'b1; host_tx_data = 8'hDD; m_tx_pop = 1'b1;
      tick();
      clear_strobes();
      ceq("R10 full both: pop wins", tx_level, 7);
      ceq("R10 full both: overflow", tx_ovf, 1);
      ceq("R10 full both: head", m_tx_data, 8'hC1);
   endtask

   initial begin
      t_reset();
      t_order();
      t_overflow();
      t_underflow();
      t_nonowner();
      t_triggers();
      t_flush();
      t_simul();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule